// File: doc/BRIEF.md
# Three-Slot Receive Message FIFO

This block sits between a bus protocol engine and the software-visible receive registers of a controller-area-network node. It keeps up to three received frames in hardware. Software only ever sees the oldest one, through a single output mailbox, along with a two-bit pending count and an overrun flag. Software pops the output mailbox with a one-cycle release pulse. Occupancy moves through five states: empty, one, two or three pending, and overrun.

The protocol engine presents a frame's identifier, length code and payload together with an end-of-frame strobe. A companion flag reports whether the frame was free of errors up to the second-last end-of-frame bit, and a single accept input carries the identifier filter verdict. A frame is stored only when all three are high.

Each stored frame carries a 16-bit timestamp. It comes from a free-running counter that advances once per bit-time tick. The counter value is latched when the engine signals the sample point of the start-of-frame bit.

Top module: `can_rx_fifo3`

## Requirements
- R1: After reset, pend_cnt is 0, and ovr_flag, irq_full and irq_ovr are all 0.
- R2: A frame is committed only when frame_end, frame_ok and filt_pass are all high in the same cycle. Any other combination leaves the count, the flag and the output mailbox unchanged.
- R3: A commit in the empty, one or two state raises pend_cnt by one. pend_cnt encodes the states as 2'b00 (empty), 2'b01, 2'b10, 2'b11 (three pending) and 2'b11 (overrun).
- R4: The output mailbox (out_id, out_dlc, out_data, out_ts) always presents the oldest stored frame. Frames leave in arrival order.
- R5: A release (rel_req high for one cycle) lowers pend_cnt by one and exposes the next frame. A release while empty is ignored and leaves the read position unchanged.
- R6: A commit with three frames pending and no release in that cycle sets ovr_flag and discards the new frame. A commit while already in overrun is also discarded. The stored frames stay unchanged in both cases.
- R7: A release in overrun moves pend_cnt to 2 while ovr_flag stays set. ovr_flag stays set until ovr_clr is pulsed high, and it reads 0 in the cycle after that pulse unless a discard happens in the same cycle.
- R8: A commit and a release in the same cycle with at least one frame pending keep pend_cnt unchanged. The read position advances and the new frame is stored at the tail, even when three frames are pending.
- R9: out_ts equals the number of bit_tick pulses seen since reset, modulo 2^16, at the cycle in which sof_sample was high for that frame.
- R10: irq_full is high exactly in the three-pending state, which excludes overrun. irq_ovr is high whenever ovr_flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bus bit time; advances the timestamp counter |
| sof_sample | input | 1 | Sample point of the start-of-frame bit; latches the counter |
| frame_end | input | 1 | Frame reception finished (late end-of-frame point) |
| frame_ok | input | 1 | No protocol error up to the second-last end-of-frame bit |
| filt_pass | input | 1 | Identifier filter accepted the frame |
| in_id | input | 29 | Received identifier |
| in_dlc | input | 4 | Received data length code |
| in_data | input | 64 | Received payload, eight bytes |
| rel_req | input | 1 | Software release of the output mailbox |
| ovr_clr | input | 1 | Software clears the overrun flag (write of 1) |
| out_id | output | 29 | Identifier of the oldest frame |
| out_dlc | output | 4 | Length code of the oldest frame |
| out_data | output | 64 | Payload of the oldest frame |
| out_ts | output | 16 | Timestamp of the oldest frame |
| pend_cnt | output | 2 | Pending-message count |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq_full | output | 1 | Three frames pending |
| irq_ovr | output | 1 | Overrun flag set |

## Verification
The bench feeds frames that fail only the error check or only the filter. A design that stored them would show a nonzero count. It overfills the FIFO twice and then drains it. A design that overwrote a slot on overrun would expose a discarded identifier as the second or third frame. A release is issued while empty and followed by a new frame, which catches a read pointer that moves when nothing is stored. Commit and release are driven in the same cycle with one and with three frames pending. A design that treated the full case as an overrun would set the flag and drop the frame. Timestamps are checked against a tick count kept by the bench, which exposes a counter latched at the wrong event.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;
  localparam int TS_W   = 16;
  localparam int DEPTH  = 3;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
    logic [TS_W-1:0]   ts;
  } rx_frame_t;

  typedef enum logic [2:0] {
    Q_EMPTY = 3'd0,
    Q_ONE   = 3'd1,
    Q_TWO   = 3'd2,
    Q_THREE = 3'd3,
    Q_OVER  = 3'd4
  } q_state_t;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] state_count(input q_state_t s);
    case (s)
      Q_EMPTY: return CNT_W'(0);
      Q_ONE:   return CNT_W'(1);
      Q_TWO:   return CNT_W'(2);
      default: return CNT_W'(3);
    endcase
  endfunction

  function automatic q_state_t state_next(input q_state_t s, input logic put,
                                          input logic take, input logic clr);
    case (s)
      Q_EMPTY: return put ? Q_ONE : Q_EMPTY;
      Q_ONE:   return (put == take) ? Q_ONE : (put ? Q_TWO : Q_EMPTY);
      Q_TWO:   return (put == take) ? Q_TWO : (put ? Q_THREE : Q_ONE);
      Q_THREE: return (put == take) ? Q_THREE : (put ? Q_OVER : Q_TWO);
      Q_OVER: begin
        if (take)              return put ? Q_THREE : Q_TWO;
        else if (clr && !put)  return Q_THREE;
        else                   return Q_OVER;
      end
      default: return Q_EMPTY;
    endcase
  endfunction
endpackage

// File: rtl/rxq_stamp.sv
module rxq_stamp
  import rxq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            sof_sample,
  output logic [TS_W-1:0] ts_now,
  output logic [TS_W-1:0] sof_ts
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_now <= '0;
      sof_ts <= '0;
    end else begin
      if (bit_tick)   ts_now <= ts_now + TS_W'(1);
      if (sof_sample) sof_ts <= ts_now;
    end
  end

  assert_tick_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> ts_now == $past(ts_now) + TS_W'(1));
  assert_sof_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sof_sample |=> sof_ts == $past(ts_now));
endmodule

// File: rtl/rxq_occupancy.sv
module rxq_occupancy
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             release_req,
  input  logic             ovr_clr,
  output q_state_t         state,
  output logic [CNT_W-1:0] cnt,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             wr_en,
  output logic             ovr_flag
);
  logic rel_ok;
  logic discard;

  assign rel_ok  = release_req && (state != Q_EMPTY);
  assign wr_en   = commit && (rel_ok || (state != Q_THREE && state != Q_OVER));
  assign discard = commit && !wr_en;
  assign cnt     = state_count(state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= Q_EMPTY;
      head     <= '0;
      tail     <= '0;
      ovr_flag <= 1'b0;
    end else begin
      state <= state_next(state, commit, rel_ok, ovr_clr);
      if (rel_ok) head <= ptr_next(head);
      if (wr_en)  tail <= ptr_next(tail);
      if (discard)      ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !release_req && !ovr_clr) |=> $stable(state) && $stable(head));
  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !release_req && state != Q_THREE && state != Q_OVER)
      |=> cnt == $past(cnt) + CNT_W'(1));
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (release_req && !commit && state != Q_OVER && state != Q_EMPTY)
      |=> cnt == $past(cnt) - CNT_W'(1));
  assert_empty_rel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (release_req && state == Q_EMPTY) |=> $stable(head));
  assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !release_req && state == Q_THREE) |=> ovr_flag && state == Q_OVER);
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
  assert_ovr_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == Q_OVER && release_req && !commit && !ovr_clr) |=> cnt == CNT_W'(2) && ovr_flag);
  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && release_req && state != Q_EMPTY) |=> $stable(cnt) && head != $past(head));
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  rx_frame_t        wr_frame,
  input  logic [PTR_W-1:0] rd_ptr,
  output rx_frame_t        rd_frame
);
  rx_frame_t slot_view [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rx_frame_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                q <= '0;
      else if (wr_en && wr_ptr == PTR_W'(g))     q <= wr_frame;
    end
    assign slot_view[g] = q;
  end

  always_comb begin
    rd_frame = slot_view[0];
    for (int i = 1; i < DEPTH; i++)
      if (rd_ptr == PTR_W'(i)) rd_frame = slot_view[i];
  end
endmodule

// File: rtl/can_rx_fifo3.sv
module can_rx_fifo3
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              sof_sample,
  input  logic              frame_end,
  input  logic              frame_ok,
  input  logic              filt_pass,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DLC_W-1:0]  in_dlc,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rel_req,
  input  logic              ovr_clr,
  output logic [ID_W-1:0]   out_id,
  output logic [DLC_W-1:0]  out_dlc,
  output logic [DATA_W-1:0] out_data,
  output logic [TS_W-1:0]   out_ts,
  output logic [1:0]        pend_cnt,
  output logic              ovr_flag,
  output logic              irq_full,
  output logic              irq_ovr
);
  logic             commit;
  logic [TS_W-1:0]  ts_now;
  logic [TS_W-1:0]  sof_ts;
  q_state_t         state;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] head;
  logic [PTR_W-1:0] tail;
  logic             wr_en;
  rx_frame_t        wr_frame;
  rx_frame_t        rd_frame;

  assign commit = frame_end && frame_ok && filt_pass;

  rxq_stamp u_stamp (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sof_sample(sof_sample),
    .ts_now(ts_now), .sof_ts(sof_ts)
  );

  rxq_occupancy u_occ (
    .clk(clk), .rst_n(rst_n), .commit(commit), .release_req(rel_req),
    .ovr_clr(ovr_clr), .state(state), .cnt(cnt), .head(head), .tail(tail),
    .wr_en(wr_en), .ovr_flag(ovr_flag)
  );

  always_comb begin
    wr_frame.id   = in_id;
    wr_frame.dlc  = in_dlc;
    wr_frame.data = in_data;
    wr_frame.ts   = sof_ts;
  end

  rxq_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(tail),
    .wr_frame(wr_frame), .rd_ptr(head), .rd_frame(rd_frame)
  );

  assign out_id   = rd_frame.id;
  assign out_dlc  = rd_frame.dlc;
  assign out_data = rd_frame.data;
  assign out_ts   = rd_frame.ts;
  assign pend_cnt = cnt[1:0];
  assign irq_full = (state == Q_THREE);
  assign irq_ovr  = ovr_flag;

  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !(frame_ok && filt_pass) && !rel_req && !ovr_clr)
      |=> $stable(pend_cnt) && $stable(out_id) && $stable(ovr_flag));
  assert_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && pend_cnt == 2'd3 && !rel_req) |=> pend_cnt == 2'd3 && $stable(out_id) && ovr_flag);
  assert_irq_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> pend_cnt == 2'd3);
  assert_irq_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == 2'd3 && !irq_full) |-> irq_ovr || $past(ovr_clr));
endmodule

// File: tb/sim_can_rx_fifo3.sv
module sim_can_rx_fifo3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0, sof_sample = 1'b0;
  logic        frame_end = 1'b0, frame_ok = 1'b0, filt_pass = 1'b0;
  logic [28:0] in_id = '0;
  logic [3:0]  in_dlc = '0;
  logic [63:0] in_data = '0;
  logic        rel_req = 1'b0, ovr_clr = 1'b0;
  logic [28:0] out_id;
  logic [3:0]  out_dlc;
  logic [63:0] out_data;
  logic [15:0] out_ts;
  logic [1:0]  pend_cnt;
  logic        ovr_flag, irq_full, irq_ovr;

  int checks = 0;
  int fails = 0;
  int tk = 0;
  bit done = 0;

  always #5 clk = ~clk;

  can_rx_fifo3 u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sof_sample(sof_sample),
    .frame_end(frame_end), .frame_ok(frame_ok), .filt_pass(filt_pass),
    .in_id(in_id), .in_dlc(in_dlc), .in_data(in_data), .rel_req(rel_req),
    .ovr_clr(ovr_clr), .out_id(out_id), .out_dlc(out_dlc), .out_data(out_data),
    .out_ts(out_ts), .pend_cnt(pend_cnt), .ovr_flag(ovr_flag),
    .irq_full(irq_full), .irq_ovr(irq_ovr)
  );

  function automatic logic [63:0] pay(input logic [28:0] id);
    return {35'h5A5A5A5A5, id} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; step(); bit_tick = 1'b0;
      tk++;
    end
  endtask

  task automatic sof();
    sof_sample = 1'b1; step(); sof_sample = 1'b0;
  endtask

  task automatic cyc(input logic fe, input logic ok, input logic acc,
                     input logic rel, input logic clr, input logic [28:0] id);
    frame_end = fe; frame_ok = ok; filt_pass = acc; rel_req = rel; ovr_clr = clr;
    in_id = id; in_dlc = id[3:0]; in_data = pay(id);
    step();
    frame_end = 1'b0; frame_ok = 1'b0; filt_pass = 1'b0; rel_req = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend_cnt, 0);
    chk("R1 ovr", ovr_flag, 0);
    chk("R1 irq_full", irq_full, 0);
    chk("R1 irq_ovr", irq_ovr, 0);
  endtask

  task automatic t_filter();
    ticks(5); sof();
    cyc(1, 0, 1, 0, 0, 29'h101);
    chk("R2 error frame", pend_cnt, 0);
    cyc(1, 1, 0, 0, 0, 29'h102);
    chk("R2 filtered frame", pend_cnt, 0);
    cyc(1, 1, 1, 0, 0, 29'h103);
    chk("R3 one", pend_cnt, 2'b01);
    chk("R4 id", out_id, 29'h103);
    chk("R4 dlc", out_dlc, 4'h3);
    chk("R4 data", out_data, pay(29'h103));
    chk("R9 ts", out_ts, 5);
  endtask

  task automatic t_fill();
    ticks(3); sof();
    cyc(1, 1, 1, 0, 0, 29'h200);
    chk("R3 two", pend_cnt, 2'b10);
    chk("R4 head kept", out_id, 29'h103);
    ticks(4); sof();
    cyc(1, 1, 1, 0, 0, 29'h300);
    chk("R3 three", pend_cnt, 2'b11);
    chk("R10 full", irq_full, 1);
    chk("R10 no ovr", irq_ovr, 0);
  endtask

  task automatic t_overrun();
    cyc(1, 1, 1, 0, 0, 29'h400);
    chk("R6 cnt", pend_cnt, 2'b11);
    chk("R6 flag", ovr_flag, 1);
    chk("R10 irq_ovr", irq_ovr, 1);
    chk("R10 full off", irq_full, 0);
    chk("R6 head", out_id, 29'h103);
    cyc(1, 1, 1, 0, 0, 29'h500);
    chk("R6 second discard", pend_cnt, 2'b11);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R7 cnt", pend_cnt, 2'b10);
    chk("R7 flag kept", ovr_flag, 1);
    chk("R6 order 2", out_id, 29'h200);
    chk("R9 ts 2", out_ts, 8);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 order 3", out_id, 29'h300);
    chk("R9 ts 3", out_ts, 12);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 drained", pend_cnt, 0);
    chk("R7 flag after drain", ovr_flag, 1);
  endtask

  task automatic t_empty_release();
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 empty release", pend_cnt, 0);
    ticks(2); sof();
    cyc(1, 1, 1, 0, 0, 29'h600);
    chk("R5 after empty release cnt", pend_cnt, 1);
    chk("R5 after empty release id", out_id, 29'h600);
    chk("R9 ts 14", out_ts, 14);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R7 clear", ovr_flag, 0);
    chk("R10 irq_ovr clear", irq_ovr, 0);
  endtask

  task automatic t_same_cycle();
    cyc(1, 1, 1, 1, 0, 29'h700);
    chk("R8 cnt one", pend_cnt, 1);
    chk("R8 id", out_id, 29'h700);
    chk("R8 data", out_data, pay(29'h700));
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 empty", pend_cnt, 0);
    cyc(1, 1, 1, 0, 0, 29'h801);
    cyc(1, 1, 1, 0, 0, 29'h802);
    cyc(1, 1, 1, 0, 0, 29'h803);
    chk("R3 refill", pend_cnt, 3);
    cyc(1, 1, 1, 1, 0, 29'h804);
    chk("R8 full cnt", pend_cnt, 3);
    chk("R8 no overrun", ovr_flag, 0);
    chk("R8 head", out_id, 29'h802);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R4 order a", out_id, 29'h803);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R8 tail frame", out_id, 29'h804);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 final", pend_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_filter();
    t_fill();
    t_overrun();
    t_empty_release();
    t_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule